// File: doc/BRIEF.md
# Event Record Sector Formatter

This block turns one recorded event into a flat byte stream that a block-oriented file transfer can send. After a start pulse it emits a fixed-length header, then one or more data records. Each record opens with a run of packed time-code bytes and continues with a fixed number of scans. A scan carries one 12-bit sample for each enabled channel. Each sample is widened to a 16-bit word whose upper four bits are zero and is sent low byte first.

The block holds no event data itself. It drives a fetch address made of a record number, a byte or scan index and a channel number. The source answers in the same cycle on three read ports: the header byte, the time-code byte and the sample word. The stream is cut into 128-byte sectors. If the content does not fill the last sector, the block fills the rest with the little-endian zero-volt sample code. The output is a byte with a valid/ready handshake. A sector strobe travels with the last byte of each sector, and a done pulse follows the final byte.

Top module: `evt_sector_fmt`

## Requirements
- R1: After reset, and while reset is held, out_valid, sector_end and event_done are all 0.
- R2: A start pulse while no event is in progress captures ch_count and rec_count. A start pulse during an event has no effect on that event's stream.
- R3: Bytes 0 to 255 of the stream are hdr_byte, presented while fetch_idx runs 0 to 255 in order.
- R4: Each record begins with 32 time-code bytes, taken from tc_byte while fetch_rec holds the record number and fetch_idx runs 0 to 31. The 256 scans of that record follow, with fetch_idx equal to the scan number.
- R5: Each word of a scan is emitted as two bytes: first samp_word[7:0], then {4'b0000, samp_word[11:8]}. samp_word[15:12] never reaches the output.
- R6: A scan holds ch_count words, with fetch_ch running from 0 upward. ch_count of 1, 2 or 3 gives that many words, and ch_count 0 is handled as 1.
- R7: An event holds rec_count records. With rec_count 0 the stream is the header alone.
- R8: The stream is padded up to a multiple of 128 bytes. Pad bytes at even stream positions are 8'h00 and at odd positions 8'h08, which is sample code 800h sent low byte first. A stream whose content already ends on a sector boundary gets no padding.
- R9: sector_end is 1 with exactly those bytes whose stream position is 127 modulo 128.
- R10: While out_valid is 1 and out_ready is 0, out_data, sector_end and out_valid hold their values. Each byte is delivered exactly once, in order.
- R11: event_done is a one-cycle pulse in the cycle after the final byte is accepted, and out_valid is 0 in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin an event (taken only when idle) |
| ch_count | input | 2 | Words per scan, 1 to 3 (0 treated as 1) |
| rec_count | input | REC_W | Number of data records in the event |
| fetch_rec | output | REC_W | Record number being read |
| fetch_idx | output | IDX_W | Header byte, time-code byte or scan index being read |
| fetch_ch | output | 2 | Channel of the sample being read |
| hdr_byte | input | 8 | Header byte at fetch_idx |
| tc_byte | input | 8 | Time-code byte at fetch_rec/fetch_idx |
| samp_word | input | 16 | Sample at fetch_rec/fetch_idx/fetch_ch, bits 11:0 used |
| out_data | output | 8 | Stream byte |
| out_valid | output | 1 | out_data holds a byte |
| out_ready | input | 1 | Sink accepts the byte this cycle |
| sector_end | output | 1 | Current byte is the last of a 128-byte sector |
| event_done | output | 1 | Pulse after the final byte is accepted |

## Verification
The stream is rebuilt byte by byte from the requirements. The bench runs events with one, two and three channels, a zero channel count, zero to four records, and sink readiness that is always on, toggling or irregular. Channel counts with different record sizes show whether the scan word count and the channel order are right. Record counts show whether the time-code interleaving is right. The bench also compares a padded tail against a stream whose content ends on a sector boundary. Because each sample's unused nibble is nonzero, a leak of it into the high byte shows up. Stalls show whether bytes are lost or duplicated. A start pulse in the middle of an event and a reset in the middle of an event test R2 and R1.

// File: rtl/evt_fmt_pkg.sv
// Shared types for the event sector formatter.
// Assumes: at most three channels per scan; sector length is even.
package evt_fmt_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_HDR,
        ST_TC,
        ST_DATA,
        ST_PAD
    } fmt_state_e;
endpackage

// File: rtl/evt_fmt_seq.sv
// Stream position sequencer. Walks header, time-code and scan bytes and
// the pad tail. Drives the fetch address for the current byte.
// Assumes: 'advance' is 1 only while state is not idle; SEC_BYTES is even.
module evt_fmt_seq
    import evt_fmt_pkg::*;
#(
    parameter int HDR_BYTES = 256,
    parameter int TC_BYTES  = 32,
    parameter int SCANS     = 256,
    parameter int SEC_BYTES = 128,
    parameter int REC_W     = 8,
    parameter int IDX_W     = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [1:0]       ch_count,
    input  logic [REC_W-1:0] rec_count,
    input  logic             advance,
    output fmt_state_e       state,
    output logic             hi_byte,
    output logic             pad_odd,
    output logic             sec_last,
    output logic             strm_last,
    output logic [REC_W-1:0] fetch_rec,
    output logic [IDX_W-1:0] fetch_idx,
    output logic [1:0]       fetch_ch
);
    localparam int CNT_MAX = (HDR_BYTES > TC_BYTES) ? HDR_BYTES : TC_BYTES;
    localparam int CNT_W   = $clog2(CNT_MAX);
    localparam int SCAN_W  = $clog2(SCANS);
    localparam int SEC_W   = $clog2(SEC_BYTES);

    logic [CNT_W-1:0]  cnt;
    logic [SCAN_W-1:0] scan;
    logic [1:0]        ch;
    logic [1:0]        nch;
    logic [REC_W-1:0]  rec;
    logic [REC_W-1:0]  nrec;
    logic [SEC_W-1:0]  sec_pos;
    logic              hdr_end, tc_end, word_end, scan_end, rec_end;
    logic              content_end;

    // Decode where the current byte sits in its section.
    always_comb begin
        hdr_end     = (state == ST_HDR) && (cnt == CNT_W'(HDR_BYTES - 1));
        tc_end      = (state == ST_TC) && (cnt == CNT_W'(TC_BYTES - 1));
        word_end    = (state == ST_DATA) && hi_byte && (ch == nch - 2'd1);
        scan_end    = word_end && (scan == SCAN_W'(SCANS - 1));
        rec_end     = scan_end && (rec == nrec - REC_W'(1));
        content_end = rec_end || (hdr_end && (nrec == '0));
        sec_last    = (sec_pos == SEC_W'(SEC_BYTES - 1));
        strm_last   = sec_last && (content_end || (state == ST_PAD));
        pad_odd     = sec_pos[0];
    end

    // Present the fetch address for the byte about to be emitted.
    always_comb begin
        fetch_rec = rec;
        fetch_ch  = ch;
        fetch_idx = (state == ST_DATA) ? IDX_W'(scan) : IDX_W'(cnt);
    end

    // Capture the event setup and step through the stream on each advance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            cnt     <= '0;
            scan    <= '0;
            ch      <= '0;
            hi_byte <= 1'b0;
            rec     <= '0;
            nrec    <= '0;
            nch     <= 2'd1;
            sec_pos <= '0;
        end else if (state == ST_IDLE) begin
            if (start) begin
                state   <= ST_HDR;
                nch     <= (ch_count == 2'd0) ? 2'd1 : ch_count;
                nrec    <= rec_count;
                cnt     <= '0;
                scan    <= '0;
                ch      <= '0;
                hi_byte <= 1'b0;
                rec     <= '0;
                sec_pos <= '0;
            end
        end else if (advance) begin
            sec_pos <= sec_last ? '0 : sec_pos + SEC_W'(1);
            if (content_end) begin
                state <= sec_last ? ST_IDLE : ST_PAD;
            end else begin
                case (state)
                    ST_HDR: begin
                        cnt <= hdr_end ? '0 : cnt + CNT_W'(1);
                        if (hdr_end) state <= ST_TC;
                    end
                    ST_TC: begin
                        cnt <= tc_end ? '0 : cnt + CNT_W'(1);
                        if (tc_end) state <= ST_DATA;
                    end
                    ST_DATA: begin
                        hi_byte <= ~hi_byte;
                        if (hi_byte) begin
                            ch <= word_end ? 2'd0 : ch + 2'd1;
                            if (word_end) scan <= scan_end ? '0 : scan + SCAN_W'(1);
                            if (scan_end) begin
                                rec   <= rec + REC_W'(1);
                                state <= ST_TC;
                            end
                        end
                    end
                    ST_PAD: begin
                        if (sec_last) state <= ST_IDLE;
                    end
                    default: state <= ST_IDLE;
                endcase
            end
        end
    end

    // R6: the channel index stays below the captured word count.
    assert_ch_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DATA) |-> (ch < nch));

    // R8: padding ends only on a sector boundary.
    assert_pad_exit_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_PAD && advance) |=> (state == ST_PAD || sec_pos == '0));
endmodule

// File: rtl/evt_fmt_bytesel.sv
// Byte selector. Chooses the stream byte for the current position from
// the header, time-code and sample read ports, or forms a pad byte.
// Assumes: read ports answer combinationally to the fetch address.
module evt_fmt_bytesel
    import evt_fmt_pkg::*;
(
    input  fmt_state_e  state,
    input  logic        hi_byte,
    input  logic        pad_odd,
    input  logic [7:0]  hdr_byte,
    input  logic [7:0]  tc_byte,
    input  logic [15:0] samp_word,
    output logic [7:0]  byte_out
);
    // Pick the source by section. Sample words are cut to 12 bits and
    // sent low byte first.
    always_comb begin
        case (state)
            ST_HDR:  byte_out = hdr_byte;
            ST_TC:   byte_out = tc_byte;
            ST_DATA: byte_out = hi_byte ? {4'b0000, samp_word[11:8]} : samp_word[7:0];
            ST_PAD:  byte_out = pad_odd ? 8'h08 : 8'h00;
            default: byte_out = 8'h00;
        endcase
    end
endmodule

// File: rtl/evt_fmt_outreg.sv
// Output register with valid/ready. It loads a new byte whenever the
// slot is empty or being drained, and holds it under back-pressure.
// It also flags the end of the event.
// Assumes: 'active' means the sequencer has a byte to offer.
module evt_fmt_outreg (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       active,
    input  logic [7:0] byte_in,
    input  logic       sec_in,
    input  logic       last_in,
    input  logic       out_ready,
    output logic       advance,
    output logic [7:0] out_data,
    output logic       out_valid,
    output logic       sector_end,
    output logic       event_done
);
    logic sec_q;
    logic last_q;

    // A new byte may enter when the slot is free or leaving this cycle.
    always_comb advance = active && (!out_valid || out_ready);

    // Load, hold or drain the output slot; pulse done after the last byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_data   <= 8'h00;
            out_valid  <= 1'b0;
            sec_q      <= 1'b0;
            last_q     <= 1'b0;
            event_done <= 1'b0;
        end else begin
            if (advance) begin
                out_data  <= byte_in;
                out_valid <= 1'b1;
                sec_q     <= sec_in;
                last_q    <= last_in;
            end else if (out_ready) begin
                out_valid <= 1'b0;
            end
            event_done <= out_valid && out_ready && last_q;
        end
    end

    always_comb sector_end = sec_q && out_valid;

    // R10: a stalled byte does not change or vanish.
    assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(sector_end)));

    // R11: done follows an accepted sector-closing byte and finds the slot empty.
    assert_done_after_sector_R11: assert property (@(posedge clk) disable iff (!rst_n)
        event_done |-> ($past(sector_end && out_ready) && !out_valid));

    // R11: done is a single-cycle pulse.
    assert_done_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
        event_done |=> !event_done);
endmodule

// File: rtl/evt_sector_fmt.sv
// Event sector formatter top. Builds header, record and pad bytes into a
// sector-aligned byte stream with valid/ready output.
// Assumes: source read ports are combinational from fetch_* outputs.
module evt_sector_fmt
    import evt_fmt_pkg::*;
#(
    parameter int HDR_BYTES = 256,
    parameter int TC_BYTES  = 32,
    parameter int SCANS     = 256,
    parameter int SEC_BYTES = 128,
    parameter int REC_W     = 8,
    localparam int CNT_MAX  = (HDR_BYTES > TC_BYTES) ? HDR_BYTES : TC_BYTES,
    localparam int IDX_W    = ($clog2(CNT_MAX) > $clog2(SCANS)) ? $clog2(CNT_MAX) : $clog2(SCANS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [1:0]       ch_count,
    input  logic [REC_W-1:0] rec_count,
    output logic [REC_W-1:0] fetch_rec,
    output logic [IDX_W-1:0] fetch_idx,
    output logic [1:0]       fetch_ch,
    input  logic [7:0]       hdr_byte,
    input  logic [7:0]       tc_byte,
    input  logic [15:0]      samp_word,
    output logic [7:0]       out_data,
    output logic             out_valid,
    input  logic             out_ready,
    output logic             sector_end,
    output logic             event_done
);
    fmt_state_e state;
    logic       hi_byte, pad_odd, sec_last, strm_last, advance;
    logic [7:0] byte_nxt;

    evt_fmt_seq #(
        .HDR_BYTES(HDR_BYTES), .TC_BYTES(TC_BYTES), .SCANS(SCANS),
        .SEC_BYTES(SEC_BYTES), .REC_W(REC_W), .IDX_W(IDX_W)
    ) u_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .ch_count(ch_count),
        .rec_count(rec_count), .advance(advance), .state(state),
        .hi_byte(hi_byte), .pad_odd(pad_odd), .sec_last(sec_last),
        .strm_last(strm_last), .fetch_rec(fetch_rec),
        .fetch_idx(fetch_idx), .fetch_ch(fetch_ch)
    );

    evt_fmt_bytesel u_sel (
        .state(state), .hi_byte(hi_byte), .pad_odd(pad_odd),
        .hdr_byte(hdr_byte), .tc_byte(tc_byte), .samp_word(samp_word),
        .byte_out(byte_nxt)
    );

    evt_fmt_outreg u_out (
        .clk(clk), .rst_n(rst_n), .active(state != ST_IDLE),
        .byte_in(byte_nxt), .sec_in(sec_last), .last_in(strm_last),
        .out_ready(out_ready), .advance(advance), .out_data(out_data),
        .out_valid(out_valid), .sector_end(sector_end),
        .event_done(event_done)
    );

    // R5: a high byte of a sample word never carries the unused nibble.
    assert_hi_nibble_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (advance && state == ST_DATA && hi_byte) |=> (out_data[7:4] == 4'h0));

    // R1: nothing is offered or signalled in the cycle after reset.
    assert_reset_quiet_R1: assert property (@(posedge clk)
        !rst_n |=> (!out_valid && !event_done && !sector_end));
endmodule

// File: tb/tb_evt_sector_fmt.sv
module tb_evt_sector_fmt;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [1:0]  ch_count = 2'd1;
    logic [7:0]  rec_count = 8'd0;
    logic [7:0]  fetch_rec;
    logic [7:0]  fetch_idx;
    logic [1:0]  fetch_ch;
    logic [7:0]  hdr_byte, tc_byte;
    logic [15:0] samp_word;
    logic [7:0]  out_data;
    logic        out_valid, sector_end, event_done;
    logic        out_ready = 1'b0;

    int n_chk = 0;
    int n_bad = 0;
    int cyc_total = 0;

    always #4 clk = ~clk;

    evt_sector_fmt dut (
        .clk(clk), .rst_n(rst_n), .start(start), .ch_count(ch_count),
        .rec_count(rec_count), .fetch_rec(fetch_rec), .fetch_idx(fetch_idx),
        .fetch_ch(fetch_ch), .hdr_byte(hdr_byte), .tc_byte(tc_byte),
        .samp_word(samp_word), .out_data(out_data), .out_valid(out_valid),
        .out_ready(out_ready), .sector_end(sector_end), .event_done(event_done)
    );

    // Source memory model: values are pure functions of the fetch address.
    function automatic logic [7:0] hdr_val(int i);
        return 8'(i ^ 8'h5A);
    endfunction
    function automatic logic [7:0] tc_val(int r, int i);
        return 8'(r * 37 + i * 3 + 1);
    endfunction
    function automatic logic [15:0] smp_val(int r, int s, int c);
        logic [11:0] v;
        v = 12'(r * 1000 + s * 7 + c * 513);
        return {4'(4'hA + c), v};
    endfunction

    assign hdr_byte  = hdr_val(int'(fetch_idx));
    assign tc_byte   = tc_val(int'(fetch_rec), int'(fetch_idx));
    assign samp_word = smp_val(int'(fetch_rec), int'(fetch_idx), int'(fetch_ch));

    // Expected byte at stream position p (R3, R4, R5, R6, R8).
    function automatic logic [7:0] exp_byte(int p, int c, int r);
        int recsz, q, ri, o, d, w;
        logic [15:0] sw;
        recsz = 32 + 256 * 2 * c;
        if (p < 256) return hdr_val(p);
        q = p - 256;
        if (q < r * recsz) begin
            ri = q / recsz;
            o  = q % recsz;
            if (o < 32) return tc_val(ri, o);
            d  = o - 32;
            w  = d / 2;
            sw = smp_val(ri, w / c, w % c);
            return (d % 2 == 1) ? {4'h0, sw[11:8]} : sw[7:0];
        end
        return (p % 2 == 1) ? 8'h08 : 8'h00;
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Vector table: channel count, record count, ready pattern, mid-event start.
    localparam int NV = 7;
    localparam int V_CH  [NV] = '{3, 1, 2, 3, 0, 2, 1};
    localparam int V_REC [NV] = '{3, 2, 1, 1, 1, 4, 0};
    localparam int V_PAT [NV] = '{0, 1, 2, 1, 0, 2, 0};
    localparam int V_MID [NV] = '{0, 0, 1, 0, 0, 0, 0};

    logic [7:0] lfsr = 8'h1;

    task automatic run_event(input int c_in, input int r, input int pat, input int mid);
        int c, len, pos, cyc;
        bit done_due, seen_done;
        c   = (c_in == 0) ? 1 : c_in;
        len = 256 + r * (32 + 512 * c);
        len = ((len + 127) / 128) * 128;
        pos = 0; done_due = 0; seen_done = 0;
        @(posedge clk); #1;
        start = 1'b1; ch_count = 2'(c_in); rec_count = 8'(r);
        @(posedge clk); #1;
        start = 1'b0;
        for (cyc = 0; cyc < 30000 && !seen_done; cyc++) begin
            lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
            case (pat)
                1: out_ready = cyc[0];
                2: out_ready = lfsr[0] | lfsr[1];
                default: out_ready = 1'b1;
            endcase
            if (mid != 0) begin
                start = (cyc == 50);
                ch_count = 2'd1; rec_count = 8'd1;
            end
            @(negedge clk);
            chk(event_done == done_due, "R11 done timing", event_done, done_due);
            if (event_done) begin
                seen_done = 1;
                chk(!out_valid, "R11 idle at done", out_valid, 0);
                // R2/R7/R8: length matches captured setup, with padding.
                chk(pos == len, "R2 R7 R8 length", pos, len);
            end
            done_due = 0;
            if (out_valid && out_ready) begin
                chk(out_data == exp_byte(pos, c, r), "R3 R4 R5 R6 R8 R10 byte", out_data, exp_byte(pos, c, r));
                chk(sector_end == (pos % 128 == 127), "R9 sector strobe", sector_end, pos % 128 == 127);
                if (pos == len - 1) done_due = 1;
                pos++;
            end
            @(posedge clk); #1;
        end
        start = 1'b0;
        chk(seen_done, "R11 event finished", seen_done, 1);
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        forever begin
            @(posedge clk);
            cyc_total++;
            if (cyc_total > 150000) begin
                n_bad++;
                $display("FAIL watchdog actual=%0d expected=<150000", cyc_total);
                $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
                $finish;
            end
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(!out_valid && !event_done && !sector_end, "R1 reset state", {out_valid, event_done, sector_end}, 0);
        @(posedge clk); #1;
        rst_n = 1'b1;

        for (int v = 0; v < NV; v++)
            run_event(V_CH[v], V_REC[v], V_PAT[v], V_MID[v]);

        // R1: reset in the middle of an event clears the stream.
        @(posedge clk); #1;
        start = 1'b1; ch_count = 2'd3; rec_count = 8'd2; out_ready = 1'b0;
        @(posedge clk); #1;
        start = 1'b0;
        repeat (5) @(posedge clk);
        #1 rst_n = 1'b0;
        @(posedge clk); #1;
        @(negedge clk);
        chk(!out_valid && !event_done && !sector_end, "R1 mid-event reset", {out_valid, event_done, sector_end}, 0);
        @(posedge clk); #1;
        rst_n = 1'b1;
        out_ready = 1'b1;
        repeat (4) @(posedge clk);
        @(negedge clk);
        chk(!out_valid, "R1 stays idle after reset", out_valid, 0);

        // A fresh event after the reset still forms correctly.
        run_event(2, 1, 0, 0);

        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule